// File: doc/BRIEF.md
# Nine-Bit Multiprocessor Serial Receiver

This block receives asynchronous serial frames of eleven bit periods: a low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit. A one-cycle tick at sixteen times the bit rate paces the receiver. Each data bit and the stop bit are taken as the majority of three samples around mid-bit. A start bit that is no longer low at mid-bit is treated as a glitch, and the receiver returns to idle.

A frame that completes cleanly loads the eight data bits and the ninth bit into output registers and raises an interrupt flag. The multiprocessor enable input turns on address filtering. A frame whose ninth bit is one is an address frame and is always taken. A frame whose ninth bit is zero is a data frame; while the enable is high it is dropped, so that a node that has not been selected sleeps through traffic meant for other nodes. Software clears the enable after matching its address, and sets it again when the message ends.

Status handling follows a single clear strobe. A stop bit sampled low sets a framing-error bit. A valid frame that arrives while the flag is still set sets an overrun bit, and the registers keep the earlier frame.

Top module: `mprx_top`

## Requirements
- R1: After reset, rx_data is 0x00, and rx_bit9, rx_irq, rx_ferr and rx_ovr are all 0.
- R2: A frame is a low start bit, eight data bits least significant bit first, a ninth bit and a high stop bit. Each bit lasts 16 os_tick pulses. An accepted frame puts the eight data bits on rx_data and the ninth bit on rx_bit9.
- R3: While mp_en is 1, a frame with ninth bit 0 raises no flag and leaves rx_data and rx_bit9 unchanged.
- R4: While mp_en is 1, a frame with ninth bit 1 is accepted and sets rx_irq.
- R5: While mp_en is 0, every frame with a high stop bit is accepted and sets rx_irq, whatever its ninth bit.
- R6: A frame whose stop bit samples low sets rx_ferr, leaves rx_irq unchanged, and updates neither data register.
- R7: A frame that would be accepted while rx_irq is already 1 sets rx_ovr and leaves rx_data and rx_bit9 at the earlier frame.
- R8: A one-cycle pulse on st_clr clears rx_irq, rx_ferr and rx_ovr on the next clock edge.
- R9: A low pulse on rxd shorter than half a bit period, followed by high, is rejected as a false start and produces no frame.
- R10: Each data bit is the majority of three consecutive tick samples at mid-bit, so a disturbance covering one tick does not change the received value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial input, idle high |
| os_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| mp_en | input | 1 | Multiprocessor enable: drop frames whose ninth bit is 0 |
| st_clr | input | 1 | Status write strobe: clears the flag and the error bits |
| rx_data | output | 8 | Data bits of the last accepted frame |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| rx_ferr | output | 1 | Framing error: a stop bit sampled low |
| rx_ovr | output | 1 | Overrun: a frame arrived while the flag was set |
| rx_irq | output | 1 | Receive-complete interrupt flag |

## Verification
The failures that can show at the ports have distinct signatures. A bit counter or sample phase that is off by one shifts or corrupts rx_data and rx_bit9 on the very next frame. A fault in the filter decision shows as a wrong rx_irq value after the first data frame received with mp_en high. A fault in the priority between framing error, filtering and overrun shows in the status bits within one frame time of the event that triggers it. The checks therefore read all five outputs after every frame, using directed frames and random ones with random data, ninth bit, enable and stop-bit quality.

// File: rtl/mprx_pkg.sv
package mprx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_BITS  = 2'd2,
        ST_STOP  = 2'd3
    } rx_state_e;

    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/mprx_sync.sv
module mprx_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] stg_q;
    logic [1:0] stg_d;

    always_comb begin
        stg_d = {stg_q[0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= 2'b11;
        else        stg_q <= stg_d;
    end

    assign dout = stg_q[1];
endmodule

// File: rtl/mprx_deframer.sv
module mprx_deframer
    import mprx_pkg::*;
#(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          rx,
    output logic          frame_done,
    output logic [DW-1:0] frame_data,
    output logic          frame_bit9,
    output logic          frame_stop_ok
);
    localparam int CW  = $clog2(OSR);
    localparam int NB  = DW + 1;
    localparam int NBW = $clog2(NB + 1);
    localparam logic [CW-1:0]  C_MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0]  C_PRE  = CW'(OSR / 2 - 2);
    localparam logic [CW-1:0]  C_POST = CW'(OSR / 2);
    localparam logic [CW-1:0]  C_LAST = CW'(OSR - 1);
    localparam logic [NBW-1:0] B_LAST = NBW'(NB - 1);

    typedef struct packed {
        rx_state_e      st;
        logic [CW-1:0]  cnt;
        logic [NBW-1:0] nbit;
        logic [DW:0]    sh;
        logic [1:0]     vt;
        logic           done;
        logic           stop_ok;
    } dfr_t;

    dfr_t q, d;
    logic maj;

    assign maj = vote3(q.vt[0], q.vt[1], rx);

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (tick) begin
            unique case (q.st)
                ST_IDLE: begin
                    if (!rx) begin
                        d.st  = ST_START;
                        d.cnt = '0;
                    end
                end
                ST_START: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == C_MID && rx) begin
                        d.st = ST_IDLE;
                    end else if (q.cnt == C_LAST) begin
                        d.st   = ST_BITS;
                        d.cnt  = '0;
                        d.nbit = '0;
                    end
                end
                ST_BITS: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == C_PRE) d.vt[0] = rx;
                    if (q.cnt == C_MID) d.vt[1] = rx;
                    if (q.cnt == C_POST) d.sh = {maj, q.sh[DW:1]};
                    if (q.cnt == C_LAST) begin
                        d.cnt = '0;
                        if (q.nbit == B_LAST) d.st = ST_STOP;
                        else                  d.nbit = q.nbit + 1'b1;
                    end
                end
                ST_STOP: begin
                    d.cnt = q.cnt + 1'b1;
                    if (q.cnt == C_PRE) d.vt[0] = rx;
                    if (q.cnt == C_MID) d.vt[1] = rx;
                    if (q.cnt == C_POST) begin
                        d.done    = 1'b1;
                        d.stop_ok = maj;
                        d.st      = ST_IDLE;
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, default: '0};
        else        q <= d;
    end

    assign frame_done    = q.done;
    assign frame_data    = q.sh[DW-1:0];
    assign frame_bit9    = q.sh[DW];
    assign frame_stop_ok = q.stop_ok;

    // R2: the completion strobe lasts exactly one cycle
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R9: a start bit found high at mid-bit returns to idle
    a_r9_false_start: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_START && tick && q.cnt == C_MID && rx) |=> (q.st == ST_IDLE));
endmodule

// File: rtl/mprx_regs.sv
module mprx_regs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_done,
    input  logic [DW-1:0] frame_data,
    input  logic          frame_bit9,
    input  logic          frame_stop_ok,
    input  logic          mp_en,
    input  logic          st_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_ferr,
    output logic          rx_ovr,
    output logic          rx_irq
);
    typedef struct packed {
        logic [DW-1:0] data;
        logic          b9;
        logic          irq;
        logic          ferr;
        logic          ovr;
    } rreg_t;

    rreg_t q, d;
    logic  filtered;

    assign filtered = mp_en && !frame_bit9;

    always_comb begin
        d = q;
        if (st_clr) begin
            d.irq  = 1'b0;
            d.ferr = 1'b0;
            d.ovr  = 1'b0;
        end
        if (frame_done) begin
            if (!frame_stop_ok) begin
                d.ferr = 1'b1;
            end else if (filtered) begin
                d = d;
            end else if (d.irq) begin
                d.ovr = 1'b1;
            end else begin
                d.data = frame_data;
                d.b9   = frame_bit9;
                d.irq  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_data = q.data;
    assign rx_bit9 = q.b9;
    assign rx_ferr = q.ferr;
    assign rx_ovr  = q.ovr;
    assign rx_irq  = q.irq;

    // R3: a filtered data frame leaves the data registers alone
    a_r3_filter_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && mp_en && !frame_bit9) |=> ($stable(rx_data) && $stable(rx_bit9)));

    // R6: a low stop bit raises the framing error
    a_r6_ferr_set: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_stop_ok) |=> rx_ferr);

    // R7: a frame arriving on a pending flag is an overrun and keeps old data
    a_r7_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && frame_stop_ok && !(mp_en && !frame_bit9) && rx_irq && !st_clr)
        |=> (rx_ovr && $stable(rx_data) && $stable(rx_bit9)));

    // R8: clear strobe with no frame event empties the flags
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_clr && !frame_done) |=> (!rx_irq && !rx_ferr && !rx_ovr));
endmodule

// File: rtl/mprx_top.sv
module mprx_top #(
    parameter int OSR = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rxd,
    input  logic          os_tick,
    input  logic          mp_en,
    input  logic          st_clr,
    output logic [DW-1:0] rx_data,
    output logic          rx_bit9,
    output logic          rx_ferr,
    output logic          rx_ovr,
    output logic          rx_irq
);
    logic          rx_s;
    logic          f_done;
    logic [DW-1:0] f_data;
    logic          f_bit9;
    logic          f_stop_ok;

    mprx_sync u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rx_s)
    );

    mprx_deframer #(.OSR(OSR), .DW(DW)) u_dfr (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (os_tick),
        .rx           (rx_s),
        .frame_done   (f_done),
        .frame_data   (f_data),
        .frame_bit9   (f_bit9),
        .frame_stop_ok(f_stop_ok)
    );

    mprx_regs #(.DW(DW)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done   (f_done),
        .frame_data   (f_data),
        .frame_bit9   (f_bit9),
        .frame_stop_ok(f_stop_ok),
        .mp_en        (mp_en),
        .st_clr       (st_clr),
        .rx_data      (rx_data),
        .rx_bit9      (rx_bit9),
        .rx_ferr      (rx_ferr),
        .rx_ovr       (rx_ovr),
        .rx_irq       (rx_irq)
    );
endmodule

// File: tb/mprx_top_test.sv
`timescale 1ns/1ps
module mprx_top_test;
    localparam int BITCLK = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       os_tick = 1'b0;
    logic       mp_en = 1'b0;
    logic       st_clr = 1'b0;
    logic [7:0] rx_data;
    logic       rx_bit9, rx_ferr, rx_ovr, rx_irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [7:0] e_data = 8'h00;
    logic       e_b9 = 1'b0, e_irq = 1'b0, e_ferr = 1'b0, e_ovr = 1'b0;

    mprx_top uut (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
        .mp_en(mp_en), .st_clr(st_clr), .rx_data(rx_data),
        .rx_bit9(rx_bit9), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .rx_irq(rx_irq)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                os_tick = (k == 3);
            end
        end
    end

    function automatic logic [11:0] pack_st(input logic [7:0] dt, input logic b9,
                                            input logic irq, input logic fe, input logic ov);
        return {ov, fe, irq, b9, dt};
    endfunction

    task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual {ovr,ferr,irq,b9,data}=%h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, pack_st(rx_data, rx_bit9, rx_irq, rx_ferr, rx_ovr),
            pack_st(e_data, e_b9, e_irq, e_ferr, e_ovr));
    endtask

    // expected effect of one frame, taken from R3..R7
    task automatic model_frame(input logic [7:0] dt, input logic b9, input logic stop);
        if (!stop)               e_ferr = 1'b1;
        else if (mp_en && !b9)   e_irq = e_irq;
        else if (e_irq)          e_ovr = 1'b1;
        else begin
            e_data = dt;
            e_b9   = b9;
            e_irq  = 1'b1;
        end
    endtask

    task automatic drive_bit(input logic v, input bit glitch);
        for (int i = 0; i < BITCLK; i++) begin
            rxd = (glitch && i >= 30 && i < 34) ? ~v : v;
            @(negedge clk);
        end
    endtask

    task automatic send_frame(input logic [7:0] dt, input logic b9, input logic stop,
                              input int gbit);
        drive_bit(1'b0, 1'b0);
        for (int i = 0; i < 8; i++) drive_bit(dt[i], gbit == i);
        drive_bit(b9, gbit == 8);
        drive_bit(stop, 1'b0);
        rxd = 1'b1;
        repeat (48) @(negedge clk);
        model_frame(dt, b9, stop);
    endtask

    task automatic do_clear();
        st_clr = 1'b1;
        @(negedge clk);
        st_clr = 1'b0;
        @(negedge clk);
        e_irq = 1'b0; e_ferr = 1'b0; e_ovr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        chk_all("R1 reset state");
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        chk_all("R1 after reset release");

        // R5 / R2: mp off, data frame accepted
        mp_en = 1'b0;
        send_frame(8'hA5, 1'b0, 1'b1, -1);
        chk_all("R5 R2 data frame mp off");
        do_clear();
        chk_all("R8 clear after accept");

        // R3: mp on, data frame dropped
        mp_en = 1'b1;
        send_frame(8'h3C, 1'b0, 1'b1, -1);
        chk_all("R3 data frame filtered");

        // R4: mp on, address frame accepted
        send_frame(8'h81, 1'b1, 1'b1, -1);
        chk_all("R4 address frame mp on");
        do_clear();

        // R5: mp off, address frame also accepted
        mp_en = 1'b0;
        send_frame(8'h7E, 1'b1, 1'b1, -1);
        chk_all("R5 address frame mp off");
        do_clear();

        // R6: bad stop bit
        send_frame(8'hF0, 1'b1, 1'b0, -1);
        chk_all("R6 framing error");
        do_clear();
        chk_all("R8 clear framing error");

        // R7: overrun keeps earlier data
        send_frame(8'h12, 1'b0, 1'b1, -1);
        send_frame(8'h34, 1'b1, 1'b1, -1);
        chk_all("R7 overrun");
        do_clear();
        chk_all("R8 clear overrun");

        // R9: false start then a real frame
        rxd = 1'b0;
        repeat (12) @(negedge clk);
        rxd = 1'b1;
        repeat (200) @(negedge clk);
        chk_all("R9 false start ignored");
        send_frame(8'hC3, 1'b0, 1'b1, -1);
        chk_all("R9 frame after false start");
        do_clear();

        // R10: one-tick disturbance inside data and ninth bits
        send_frame(8'h5A, 1'b1, 1'b1, 3);
        chk_all("R10 majority data bit");
        do_clear();
        send_frame(8'h0F, 1'b0, 1'b1, 8);
        chk_all("R10 majority ninth bit");
        do_clear();

        // random mix: R2 R3 R4 R5 R6
        for (int n = 0; n < 40; n++) begin
            logic [7:0] dt;
            logic       b9, sp;
            dt    = 8'($urandom);
            b9    = 1'($urandom);
            sp    = ($urandom % 8) != 0;
            mp_en = 1'($urandom);
            send_frame(dt, b9, sp, -1);
            chk_all("R2 random frame");
            if (e_irq || e_ferr) do_clear();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule